// File: doc/BRIEF.md
# Halfword-Select Signed Multiplier

This unit performs the multiply step of DSP-style integer operations. It takes two 32-bit operands and a 3-bit operation code. The code selects which 16-bit half of each operand takes part, or whether operand A takes part as a full word. All inputs to the multiply are two's complement and are sign-extended first.

In the four halfword modes, one signed 16-bit half of A is multiplied by one signed 16-bit half of B, and the full 32-bit product is returned. In the two word modes, the whole signed 32-bit A is multiplied by one signed 16-bit half of B. The 48-bit product is formed, and its upper 32 bits (bits 47 down to 16) are returned.

The unit starts an operation when it sees a one-cycle `start` pulse. The result is registered, and `valid` is raised for exactly one cycle on the following clock edge. The unit sets no flags and does no saturation.

Top module: `halfsel_mul`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released with no start, `result` is 0 and `valid` is 0.
- R2: `valid` is high in the cycle after a cycle in which `start` was high, and low in the cycle after a cycle in which `start` was low.
- R3: When `start` is low, `result` keeps its previous value, whatever `opcode`, `op_a` and `op_b` do.
- R4: Opcode 0 (bottom-bottom) returns signed A[15:0] times signed B[15:0] as a 32-bit two's complement product.
- R5: Opcode 1 (bottom-top) returns signed A[15:0] times signed B[31:16].
- R6: Opcode 2 (top-bottom) returns signed A[31:16] times signed B[15:0].
- R7: Opcode 3 (top-top) returns signed A[31:16] times signed B[31:16]. The corner case -32768 times -32768 gives 0x40000000 and does not wrap.
- R8: Opcode 4 (word-bottom) returns bits [47:16] of the 48-bit product of signed A[31:0] and signed B[15:0].
- R9: Opcode 5 (word-top) returns bits [47:16] of the 48-bit product of signed A[31:0] and signed B[31:16].
- R10: Opcodes 6 and 7 return a result of 0, and `valid` still follows the start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the current operands and opcode |
| opcode | input | 3 | Operand selection: 0 BB, 1 BT, 2 TB, 3 TT, 4 WB, 5 WT, 6/7 zero |
| op_a | input | 32 | Operand A (halves or full word, signed) |
| op_b | input | 32 | Operand B (one half is used, signed) |
| result | output | 32 | Registered product or product slice |
| valid | output | 1 | High for one cycle when `result` holds a new value |

## Verification
The assertions assume that `opcode`, `op_a` and `op_b` are valid and stable in any cycle in which `start` is high. They also assume that `start` never rises while `rst_n` is low. The checks on results compare against the registered values of these inputs from one cycle earlier, so input values in cycles without `start` are not constrained. The bench drives all inputs on the falling edge and holds `start` high for one cycle per operation. Between operations it scrambles the operands and opcode with `start` low, which exercises the hold behaviour while staying inside these assumptions.

// File: rtl/hmul_pkg.sv
package hmul_pkg;

    // Operand selection codes; codes above OP_WT yield a zero result.
    typedef enum logic [2:0] {
        OP_BB = 3'd0,
        OP_BT = 3'd1,
        OP_TB = 3'd2,
        OP_TT = 3'd3,
        OP_WB = 3'd4,
        OP_WT = 3'd5
    } hmul_op_e;

    localparam int unsigned HMUL_OP_W = 3;

    // A word-mode code has bit 2 set and bit 1 clear.
    function automatic logic op_is_word(input logic [HMUL_OP_W-1:0] op);
        return op[2] & ~op[1];
    endfunction

    // Codes 6 and 7 are the only unused ones.
    function automatic logic op_is_legal(input logic [HMUL_OP_W-1:0] op);
        return ~(op[2] & op[1]);
    endfunction

endpackage

// File: rtl/hmul_opsel.sv
module hmul_opsel
    import hmul_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [HMUL_OP_W-1:0]       op,
    input  logic [DATA_W-1:0]          a_in,
    input  logic [DATA_W-1:0]          b_in,
    output logic signed [DATA_W-1:0]   a_sel,
    output logic signed [DATA_W/2-1:0] b_sel,
    output logic                       word_mode,
    output logic                       legal
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] a_half;

    always_comb begin
        word_mode = op_is_word(op);
        legal     = op_is_legal(op);

        // bit 1 picks A's half, bit 0 picks B's half
        a_half = op[1] ? a_in[DATA_W-1:HALF_W] : a_in[HALF_W-1:0];
        b_sel  = op[0] ? b_in[DATA_W-1:HALF_W] : b_in[HALF_W-1:0];

        if (word_mode) begin
            a_sel = a_in;
        end else begin
            a_sel = {{HALF_W{a_half[HALF_W-1]}}, a_half};
        end
    end

endmodule

// File: rtl/hmul_core.sv
module hmul_core #(
    parameter int unsigned A_W = 32,
    parameter int unsigned B_W = 16
) (
    input  logic signed [A_W-1:0]     a_val,
    input  logic signed [B_W-1:0]     b_val,
    output logic signed [A_W+B_W-1:0] prod
);
    localparam int unsigned P_W = A_W + B_W;

    logic signed [P_W-1:0] a_wide;
    logic signed [P_W-1:0] b_wide;

    always_comb begin
        a_wide = {{B_W{a_val[A_W-1]}}, a_val};
        b_wide = {{A_W{b_val[B_W-1]}}, b_val};
        prod   = a_wide * b_wide;
    end

endmodule

// File: rtl/hmul_pick.sv
module hmul_pick #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W+DATA_W/2-1:0] prod,
    input  logic                       word_mode,
    input  logic                       legal,
    output logic [DATA_W-1:0]          res
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned P_W    = DATA_W + HALF_W;

    always_comb begin
        if (!legal) begin
            res = '0;
        end else if (word_mode) begin
            res = prod[P_W-1:HALF_W];
        end else begin
            res = prod[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/halfsel_mul.sv
module halfsel_mul
    import hmul_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [HMUL_OP_W-1:0] opcode,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    output logic [DATA_W-1:0]    result,
    output logic                 valid
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned P_W    = DATA_W + HALF_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
    } state_t;

    logic signed [DATA_W-1:0] a_sel;
    logic signed [HALF_W-1:0] b_sel;
    logic                     word_mode;
    logic                     legal;
    logic signed [P_W-1:0]    prod;
    logic [DATA_W-1:0]        res_c;

    state_t st_d, st_q;

    hmul_opsel #(.DATA_W(DATA_W)) u_opsel (
        .op        (opcode),
        .a_in      (op_a),
        .b_in      (op_b),
        .a_sel     (a_sel),
        .b_sel     (b_sel),
        .word_mode (word_mode),
        .legal     (legal)
    );

    hmul_core #(.A_W(DATA_W), .B_W(HALF_W)) u_core (
        .a_val (a_sel),
        .b_val (b_sel),
        .prod  (prod)
    );

    hmul_pick #(.DATA_W(DATA_W)) u_pick (
        .prod      (prod),
        .word_mode (word_mode),
        .legal     (legal),
        .res       (res_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = start;
        if (start) begin
            st_d.result = res_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.result;
    assign valid  = st_q.valid;

    // valid tracks the previous cycle's start
    assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);

    // without start the output holds
    assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    // unused opcodes give zero
    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode[2] && opcode[1]) |=> (result == '0));

    // halfword products never exceed the single positive corner value
    assert_half_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !opcode[2]) |=> ($signed(result) <= $signed({2'b01, {(DATA_W-2){1'b0}}})));

    // zero B half in word mode gives zero
    assert_word_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_WB && op_b[HALF_W-1:0] == '0) |=> (result == '0));

    // positive times positive halves is never negative
    assert_pos_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_BB && !op_a[HALF_W-1] && !op_b[HALF_W-1]) |=> !result[DATA_W-1]);

endmodule

// File: tb/halfsel_mul_test.sv
`timescale 1ns/1ps
module halfsel_mul_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;
    logic        valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    halfsel_mul uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .opcode (opcode),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result),
        .valid  (valid)
    );

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, p;
        case (op)
            3'd0: begin sa = longint'($signed(a[15:0]));  sb = longint'($signed(b[15:0]));  end
            3'd1: begin sa = longint'($signed(a[15:0]));  sb = longint'($signed(b[31:16])); end
            3'd2: begin sa = longint'($signed(a[31:16])); sb = longint'($signed(b[15:0]));  end
            3'd3: begin sa = longint'($signed(a[31:16])); sb = longint'($signed(b[31:16])); end
            3'd4: begin sa = longint'($signed(a));        sb = longint'($signed(b[15:0]));  end
            3'd5: begin sa = longint'($signed(a));        sb = longint'($signed(b[31:16])); end
            default: return 32'h0;
        endcase
        p = sa * sb;
        if (op >= 3'd4) return p[47:16];
        return p[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one start pulse; samples on the falling edge after the capturing edge
    task automatic run_op(input string req, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] exp);
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = ~a; op_b = b ^ 32'h5A5A_A5A5; opcode = op + 3'd3;
        check({req, " valid"}, {31'd0, valid}, 32'd1);
        check(req, result, exp);
    endtask

    task automatic test_reset();
        check("R1 reset result", result, 32'h0);
        check("R1 reset valid", {31'd0, valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release result", result, 32'h0);
        check("R1 after release valid", {31'd0, valid}, 32'd0);
    endtask

    task automatic test_bb();
        run_op("R4 bb 3*-2", 3'd0, 32'h1234_0003, 32'h7777_FFFE, 32'hFFFF_FFFA);
        run_op("R4 bb max", 3'd0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h3FFF_0001);
        run_op("R4 bb model", 3'd0, 32'hDEAD_BEEF, 32'hCAFE_1234, model(3'd0, 32'hDEAD_BEEF, 32'hCAFE_1234));
    endtask

    task automatic test_bt();
        run_op("R5 bt 5*-7", 3'd1, 32'hFFFF_0005, 32'hFFF9_1111, 32'hFFFF_FFDD);
        run_op("R5 bt model", 3'd1, 32'h0102_8001, 32'h7FFF_0000, model(3'd1, 32'h0102_8001, 32'h7FFF_0000));
    endtask

    task automatic test_tb();
        run_op("R6 tb -1*100", 3'd2, 32'hFFFF_0009, 32'h0000_0064, 32'hFFFF_FF9C);
        run_op("R6 tb model", 3'd2, 32'h4321_0000, 32'h0000_9ABC, model(3'd2, 32'h4321_0000, 32'h0000_9ABC));
    endtask

    task automatic test_tt();
        run_op("R7 tt min*min", 3'd3, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000);
        run_op("R7 tt min*max", 3'd3, 32'h8000_FFFF, 32'h7FFF_FFFF, 32'hC000_8000);
    endtask

    task automatic test_wb();
        run_op("R8 wb shift", 3'd4, 32'h0001_0000, 32'hAAAA_0002, 32'h0000_0002);
        run_op("R8 wb -1*1", 3'd4, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF);
        run_op("R8 wb model", 3'd4, 32'h7FFF_FFFF, 32'h0000_8000, model(3'd4, 32'h7FFF_FFFF, 32'h0000_8000));
    endtask

    task automatic test_wt();
        run_op("R9 wt shift", 3'd5, 32'h0003_0000, 32'h0004_FFFF, 32'h0000_000C);
        run_op("R9 wt model", 3'd5, 32'h8000_0000, 32'h8000_0000, model(3'd5, 32'h8000_0000, 32'h8000_0000));
    endtask

    task automatic test_unused();
        run_op("R10 code6", 3'd6, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0);
        run_op("R4 bb nonzero", 3'd0, 32'h0000_0002, 32'h0000_0003, 32'h0000_0006);
        run_op("R10 code7", 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    endtask

    task automatic test_hold();
        run_op("R3 setup", 3'd3, 32'h0010_0000, 32'h0020_0000, 32'h0000_0200);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op_a = 32'h1111_1111 * (i + 3); op_b = ~op_a; opcode = 3'(i);
            check("R2 idle valid low", {31'd0, valid}, 32'd0);
            check("R3 result held", result, 32'h0000_0200);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #1;
        test_reset();
        test_bb();
        test_bt();
        test_tb();
        test_tt();
        test_wb();
        test_wt();
        test_unused();
        test_hold();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule